// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single channel of a general-purpose DMA engine. Software supplies a configuration word, a start address for each side and an item count, then pulses `start`. The channel moves one item at a time: a single-beat read on the read port, then a single-beat write on the write port. Each side is either a memory buffer or a peripheral. A memory buffer's address steps forward by the item width after every item. A peripheral's address stays fixed, and each access on that side waits for the peripheral's request line.

An item is 8, 16 or 32 bits wide. On both ports, byte-lane strobes and data placement follow the item width and the low address bits. Bytes can be reversed on the way through, so the channel can convert a buffer between big- and little-endian order in place. In normal mode the channel turns itself off after the last item. In circular mode it clears its count and reloads both working addresses, then keeps running. Sticky half-way and end-of-lap flags, each with its own enable, let software service half a buffer at a time.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `chan_on`, `rd_valid`, `wr_valid`, `cfg_err`, `half_flag`, `done_flag` and `xfer_count` are all zero.
- R2: The configuration word is captured on an accepted `start`. Its fields are: destination ID in bits 4:0, source ID in bits 9:5, item size in bits 11:10 (00 = 32-bit, 01 = 16-bit, 10 = 8-bit), byte swap in bit 12 and circular mode in bit 18. The start addresses and `xfer_len` are captured at the same time. A `start` while `chan_on` is high is ignored.
- R3: A side with ID 0 is memory, and its working address advances by 4, 2 or 1 after each item. A side with ID n ≠ 0 is a peripheral: its address never changes, and `rd_valid` or `wr_valid` for that side is high only while `periph_req[n]` is high.
- R4: A `start` with size 11 or with `xfer_len` of 0 does not turn the channel on. It sets `cfg_err` instead. The next accepted start clears `cfg_err`.
- R5: Byte lanes on both ports: a 32-bit item uses lanes 3..0. A 16-bit item uses lanes 1..0 when address bit 1 is 0, and lanes 3..2 when it is 1. An 8-bit item uses the lane equal to address bits 1:0. `wr_strb` marks exactly the lanes in use, and the item sits in those lanes of `wr_data`.
- R6: With swap set, a 32-bit item has its byte order fully reversed, and a 16-bit item has its two bytes exchanged. An 8-bit item is never altered.
- R7: Only one item is in flight at a time. Its read handshake completes before its write is offered, and `rd_valid` and `wr_valid` are never high together. With equal source and destination addresses, a buffer is therefore swapped correctly in place.
- R8: Each write handshake adds one to `xfer_count`. In normal mode, the write that brings the count to `xfer_len` drops `chan_on` on the next edge, and the count then holds at `xfer_len`.
- R9: In circular mode, the write that brings the count to the length clears the count to 0 and reloads both working addresses from the captured start addresses. `chan_on` stays high.
- R10: `half_flag` sets when the count reaches floor(length/2), provided that value is at least 1. `done_flag` sets when the count reaches the length. Both flags fire again on every circular lap and hold until a 1 on `flag_clr` bit 0 (half) or bit 1 (done); a set in the same cycle wins. `irq_half` = `half_flag & ie_half` and `irq_done` = `done_flag & ie_done`.
- R11: When `abort` is pulsed while the channel is on, an item whose read has not yet been accepted is dropped. An item whose read was accepted completes its write. The channel then goes idle, and the count and working addresses keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Channel configuration word |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| xfer_len | input | CW | Items per lap |
| start | input | 1 | Start pulse |
| abort | input | 1 | Stop at the next item boundary |
| ie_half | input | 1 | Half-way interrupt enable |
| ie_done | input | 1 | End-of-lap interrupt enable |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 half, bit 1 done |
| periph_req | input | 32 | Request line per peripheral ID |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | AW | Read address |
| rd_ready | input | 1 | Read accepted, data present |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | AW | Write address |
| wr_data | output | 32 | Write data |
| wr_strb | output | 4 | Write byte-lane enables |
| wr_ready | input | 1 | Write accepted |
| chan_on | output | 1 | Channel enable state |
| cfg_err | output | 1 | Last start refused |
| xfer_count | output | CW | Items done in this lap |
| cur_src | output | AW | Working source address |
| cur_dst | output | AW | Working destination address |
| half_flag | output | 1 | Sticky half-way flag |
| done_flag | output | 1 | Sticky end-of-lap flag |
| irq_half | output | 1 | Enabled half-way interrupt |
| irq_done | output | 1 | Enabled end-of-lap interrupt |

## Verification
The hardest case to reach is an abort that lands exactly on a read handshake. That item must then still complete its write, while an abort one cycle earlier drops the item. A circular lap boundary adds to this, because the count is cleared there and the addresses are reloaded. The stimulus runs circular transfers with randomly stalling ready and request lines across several laps, then aborts. Afterwards it compares the held count and destination address with the number of write handshakes it observed, taken modulo the length. In-place swaps read each word back after every lap, which shows whether any write overtook its own read.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_RSVD = 2'b11
  } item_sz_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic [4:0] dst_id;
    logic [4:0] src_id;
    item_sz_e   sz;
    logic       swap;
    logic       circ;
  } chan_cfg_t;

  function automatic chan_cfg_t unpack_cfg(input logic [31:0] w);
    chan_cfg_t c;
    c.dst_id = w[4:0];
    c.src_id = w[9:5];
    c.sz     = item_sz_e'(w[11:10]);
    c.swap   = w[12];
    c.circ   = w[18];
    return c;
  endfunction

  function automatic logic [2:0] step_bytes(input item_sz_e sz);
    case (sz)
      SZ_WORD: return 3'd4;
      SZ_HALF: return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [1:0] lane_offset(input item_sz_e sz, input logic [1:0] a);
    case (sz)
      SZ_WORD: return 2'd0;
      SZ_HALF: return {a[1], 1'b0};
      default: return a;
    endcase
  endfunction

  function automatic logic [3:0] lane_strobe(input item_sz_e sz, input logic [1:0] a);
    case (sz)
      SZ_WORD: return 4'b1111;
      SZ_HALF: return 4'b0011 << lane_offset(sz, a);
      default: return 4'b0001 << a;
    endcase
  endfunction

  function automatic logic [31:0] item_mask(input item_sz_e sz);
    case (sz)
      SZ_WORD: return 32'hFFFF_FFFF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [31:0] order_swap(input item_sz_e sz, input logic en,
                                             input logic [31:0] d);
    if (!en) return d;
    case (sz)
      SZ_WORD: return {d[7:0], d[15:8], d[23:16], d[31:24]};
      SZ_HALF: return {d[31:16], d[7:0], d[15:8]};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic          is_mem,
  input  item_sz_e      sz,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur <= '0;
    else if (load)
      cur <= base;
    else if (advance && is_mem)
      cur <= cur + AW'(step_bytes(sz));
  end

endmodule

// File: rtl/dma_lane_path.sv
module dma_lane_path
  import dma_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  item_sz_e    sz,
  input  logic        swap,
  input  logic [1:0]  src_lo,
  input  logic [1:0]  dst_lo,
  input  logic [31:0] rd_data,
  output logic [31:0] wr_data
);

  logic [31:0] held_q;
  logic [31:0] item_in;
  logic [1:0]  s_lane;
  logic [1:0]  d_lane;

  assign s_lane  = lane_offset(sz, src_lo);
  assign d_lane  = lane_offset(sz, dst_lo);
  assign item_in = (rd_data >> {s_lane, 3'b000}) & item_mask(sz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= '0;
    else if (capture)
      held_q <= order_swap(sz, swap, item_in);
  end

  assign wr_data = held_q << {d_lane, 3'b000};

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_half,
  input  logic       set_done,
  input  logic [1:0] clr,
  output logic       half_flag,
  output logic       done_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_flag <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (set_half)    half_flag <= 1'b1;
      else if (clr[0]) half_flag <= 1'b0;
      if (set_done)    done_flag <= 1'b1;
      else if (clr[1]) done_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_word,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] xfer_len,
  input  logic          start,
  input  logic          abort,
  input  logic          ie_half,
  input  logic          ie_done,
  input  logic [1:0]    flag_clr,
  input  logic [31:0]   periph_req,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic [31:0]   rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic [3:0]    wr_strb,
  input  logic          wr_ready,
  output logic          chan_on,
  output logic          cfg_err,
  output logic [CW-1:0] xfer_count,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic          half_flag,
  output logic          done_flag,
  output logic          irq_half,
  output logic          irq_done
);

  chan_cfg_t     cfg_in, cfg_q;
  seq_st_e       st_q;
  logic          stop_q;
  logic [CW-1:0] len_q, cnt_q, cnt_nx, half_pt;
  logic [AW-1:0] src_base_q, dst_base_q;

  // named events for the checker
  logic          cfg_bad, run_start, rd_fire, item_done, lap_end, lap_reload;
  logic          src_is_mem, dst_is_mem, src_ok, dst_ok, circ_on;
  logic [1:0]    sz_cur;
  logic [4:0]    src_id, dst_id;
  logic          addr_load;
  logic [AW-1:0] src_load_val, dst_load_val;

  wire unused_cfg_bits = ^{cfg_word[31:19], cfg_word[17:13]};

  assign cfg_in     = unpack_cfg(cfg_word);
  assign cfg_bad    = (cfg_in.sz == SZ_RSVD) || (xfer_len == '0);
  assign run_start  = start && (st_q == ST_IDLE) && !cfg_bad;

  assign src_id     = cfg_q.src_id;
  assign dst_id     = cfg_q.dst_id;
  assign sz_cur     = cfg_q.sz;
  assign circ_on    = cfg_q.circ;
  assign src_is_mem = (src_id == 5'd0);
  assign dst_is_mem = (dst_id == 5'd0);
  assign src_ok     = src_is_mem || periph_req[src_id];
  assign dst_ok     = dst_is_mem || periph_req[dst_id];

  assign rd_valid   = (st_q == ST_READ) && src_ok && !stop_q;
  assign wr_valid   = (st_q == ST_WRITE) && dst_ok;
  assign rd_fire    = rd_valid && rd_ready;
  assign item_done  = wr_valid && wr_ready;
  assign cnt_nx     = cnt_q + CW'(1);
  assign lap_end    = item_done && (cnt_nx == len_q);
  assign lap_reload = lap_end && circ_on;
  assign half_pt    = len_q >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      stop_q     <= 1'b0;
      cfg_q      <= '0;
      len_q      <= '0;
      cnt_q      <= '0;
      src_base_q <= '0;
      dst_base_q <= '0;
      cfg_err    <= 1'b0;
    end else if (run_start) begin
      cfg_q      <= cfg_in;
      len_q      <= xfer_len;
      src_base_q <= src_base;
      dst_base_q <= dst_base;
      cnt_q      <= '0;
      stop_q     <= 1'b0;
      cfg_err    <= 1'b0;
      st_q       <= ST_READ;
    end else begin
      if (start && st_q == ST_IDLE) cfg_err <= 1'b1;
      if (abort && st_q != ST_IDLE) stop_q <= 1'b1;
      case (st_q)
        ST_READ: begin
          if (stop_q) begin
            st_q   <= ST_IDLE;
            stop_q <= 1'b0;
          end else if (rd_fire) begin
            st_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (item_done) begin
            cnt_q <= lap_reload ? '0 : cnt_nx;
            if ((lap_end && !circ_on) || stop_q || abort) begin
              st_q   <= ST_IDLE;
              stop_q <= 1'b0;
            end else begin
              st_q <= ST_READ;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign addr_load    = run_start || lap_reload;
  assign src_load_val = run_start ? src_base : src_base_q;
  assign dst_load_val = run_start ? dst_base : dst_base_q;

  dma_addr_gen #(.AW(AW)) u_src_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .advance(item_done),
    .is_mem(src_is_mem), .sz(cfg_q.sz), .base(src_load_val), .cur(cur_src)
  );

  dma_addr_gen #(.AW(AW)) u_dst_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .advance(item_done),
    .is_mem(dst_is_mem), .sz(cfg_q.sz), .base(dst_load_val), .cur(cur_dst)
  );

  dma_lane_path u_lanes (
    .clk(clk), .rst_n(rst_n), .capture(rd_fire), .sz(cfg_q.sz), .swap(cfg_q.swap),
    .src_lo(cur_src[1:0]), .dst_lo(cur_dst[1:0]), .rd_data(rd_data), .wr_data(wr_data)
  );

  dma_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_half(item_done && (cnt_nx == half_pt) && (half_pt != '0)),
    .set_done(lap_end), .clr(flag_clr),
    .half_flag(half_flag), .done_flag(done_flag)
  );

  assign rd_addr    = cur_src;
  assign wr_addr    = cur_dst;
  assign wr_strb    = lane_strobe(cfg_q.sz, cur_dst[1:0]);
  assign chan_on    = (st_q != ST_IDLE);
  assign xfer_count = cnt_q;
  assign irq_half   = half_flag && ie_half;
  assign irq_done   = done_flag && ie_done;

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [31:0]   cfg_word,
  input logic [CW-1:0] xfer_len,
  input logic [31:0]   periph_req,
  input logic          rd_valid,
  input logic          wr_valid,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] wr_addr,
  input logic [3:0]    wr_strb,
  input logic          chan_on,
  input logic          cfg_err,
  input logic [CW-1:0] xfer_count,
  input logic          done_flag,
  input logic          item_done,
  input logic          lap_end,
  input logic          lap_reload,
  input logic          src_is_mem,
  input logic          dst_is_mem,
  input logic [4:0]    src_id,
  input logic [4:0]    dst_id,
  input logic [1:0]    sz_cur
);

  logic [AW-1:0] chk_step;
  always_comb begin
    case (sz_cur)
      2'b00:   chk_step = AW'(4);
      2'b01:   chk_step = AW'(2);
      default: chk_step = AW'(1);
    endcase
  end

  p_single_item_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  p_src_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !src_is_mem) |-> periph_req[src_id]);

  p_dst_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !dst_is_mem) |-> periph_req[dst_id]);

  p_fixed_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && !dst_is_mem && !lap_reload) |=> $stable(wr_addr));

  p_src_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && src_is_mem && !lap_reload) |=> (rd_addr == $past(rd_addr) + $past(chk_step)));

  p_normal_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lap_end && !lap_reload) |=> (!chan_on && xfer_count == $past(xfer_count) + CW'(1)));

  p_lap_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lap_reload |=> (chan_on && xfer_count == '0));

  p_bad_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !chan_on && (cfg_word[11:10] == 2'b11 || xfer_len == '0)) |=> (!chan_on && cfg_err));

  p_done_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lap_end |=> done_flag);

  p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && sz_cur == 2'b10) |-> ($countones(wr_strb) == 1));

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word), .xfer_len(xfer_len),
  .periph_req(periph_req), .rd_valid(rd_valid), .wr_valid(wr_valid),
  .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_strb(wr_strb), .chan_on(chan_on),
  .cfg_err(cfg_err), .xfer_count(xfer_count), .done_flag(done_flag),
  .item_done(item_done), .lap_end(lap_end), .lap_reload(lap_reload),
  .src_is_mem(src_is_mem), .dst_is_mem(dst_is_mem), .src_id(src_id),
  .dst_id(dst_id), .sz_cur(sz_cur)
);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cfg_word = '0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [CW-1:0] xfer_len = '0;
  logic          start = 1'b0, abort = 1'b0, ie_half = 1'b0, ie_done = 1'b0;
  logic [1:0]    flag_clr = '0;
  logic [31:0]   periph_req = '0;
  logic          rd_valid, rd_ready = 1'b0, wr_valid, wr_ready = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr, cur_src, cur_dst;
  logic [31:0]   rd_data, wr_data;
  logic [3:0]    wr_strb;
  logic          chan_on, cfg_err, half_flag, done_flag, irq_half, irq_done;
  logic [CW-1:0] xfer_count;

  dma_chan_seq #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .src_base(src_base), .dst_base(dst_base),
    .xfer_len(xfer_len), .start(start), .abort(abort), .ie_half(ie_half), .ie_done(ie_done),
    .flag_clr(flag_clr), .periph_req(periph_req), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .wr_ready(wr_ready), .chan_on(chan_on),
    .cfg_err(cfg_err), .xfer_count(xfer_count), .cur_src(cur_src), .cur_dst(cur_dst),
    .half_flag(half_flag), .done_flag(done_flag), .irq_half(irq_half), .irq_done(irq_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [0:255];
  logic [31:0] ref_mem [0:255];
  assign rd_data = mem[rd_addr[9:2]];

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit traffic = 0;

  // transfer model state
  logic [31:0] t_s0, t_d0;
  logic [4:0]  t_sid, t_did;
  logic [1:0]  t_sz;
  logic        t_sw;
  int          t_len, k_item, wr_seen;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int b_width(input logic [1:0] sz);
    return (sz == 2'd0) ? 4 : (sz == 2'd1) ? 2 : 1;
  endfunction

  function automatic int b_lane(input logic [1:0] sz, input logic [31:0] a);
    if (sz == 2'd0) return 0;
    if (sz == 2'd1) return (a % 4 >= 2) ? 2 : 0;
    return a % 4;
  endfunction

  function automatic logic [31:0] b_pick(input logic [1:0] sz, input logic [31:0] a,
                                         input logic [31:0] w);
    logic [31:0] r = '0;
    for (int i = 0; i < b_width(sz); i++)
      r[8*i +: 8] = w[8*(b_lane(sz, a) + i) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] b_flip(input logic [1:0] sz, input logic sw,
                                         input logic [31:0] v);
    logic [31:0] r = v;
    if (sw && sz != 2'd2)
      for (int i = 0; i < b_width(sz); i++)
        r[8*i +: 8] = v[8*(b_width(sz) - 1 - i) +: 8];
    return r;
  endfunction

  function automatic logic [3:0] b_strb(input logic [1:0] sz, input logic [31:0] a);
    logic [3:0] s = '0;
    for (int i = 0; i < b_width(sz); i++) s[b_lane(sz, a) + i] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] b_expand(input logic [3:0] s);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (s[i]) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  // bench-side port driver and write observer
  always begin
    @(negedge clk);
    if (traffic) begin
      rd_ready   = ($urandom % 4) != 0;
      wr_ready   = ($urandom % 4) != 0;
      periph_req = $urandom;
    end else begin
      rd_ready = 1'b0; wr_ready = 1'b0; periph_req = '0;
    end
    #1;
    if (wr_valid && wr_ready) begin
      logic [31:0] sa, da, it, ed;
      logic [3:0]  es;
      sa = t_s0 + ((t_sid == 0) ? k_item * b_width(t_sz) : 0);
      da = t_d0 + ((t_did == 0) ? k_item * b_width(t_sz) : 0);
      it = b_flip(t_sz, t_sw, b_pick(t_sz, sa, ref_mem[sa[9:2]]));
      es = b_strb(t_sz, da);
      ed = '0;
      for (int i = 0; i < b_width(t_sz); i++) ed[8*(b_lane(t_sz, da) + i) +: 8] = it[8*i +: 8];
      check(wr_addr == da, "R3", "write address", wr_addr, da);
      check(wr_strb == es, "R5", "write strobe", {28'd0, wr_strb}, {28'd0, es});
      check((wr_data & b_expand(es)) == ed, "R6", "write data lanes", wr_data & b_expand(es), ed);
      ref_mem[da[9:2]] = (ref_mem[da[9:2]] & ~b_expand(es)) | ed;
      mem[wr_addr[9:2]] = (mem[wr_addr[9:2]] & ~b_expand(wr_strb)) | (wr_data & b_expand(wr_strb));
      wr_seen++;
      k_item++;
      if (k_item == t_len) k_item = 0;
    end
    if (rd_valid && t_sid != 0 && !periph_req[t_sid])
      check(1'b0, "R3", "read offered without request", 32'd1, 32'd0);
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic launch(input logic [4:0] did, input logic [4:0] sid, input logic [1:0] sz,
                        input logic sw, input logic circ, input logic [31:0] s0,
                        input logic [31:0] d0, input int len);
    t_s0 = s0; t_d0 = d0; t_sid = sid; t_did = did; t_sz = sz; t_sw = sw;
    t_len = len; k_item = 0; wr_seen = 0;
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
    @(negedge clk);
    cfg_word = {13'd0, circ, 5'd0, sw, sz, sid, did};
    src_base = s0; dst_base = d0; xfer_len = CW'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (chan_on && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 2'b11;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  task automatic run_normal(input logic [4:0] did, input logic [4:0] sid, input logic [1:0] sz,
                            input logic sw, input logic [31:0] s0, input logic [31:0] d0,
                            input int len);
    logic [31:0] es, ed;
    launch(did, sid, sz, sw, 1'b0, s0, d0, len);
    wait_idle();
    es = s0 + ((sid == 0) ? len * b_width(sz) : 0);
    ed = d0 + ((did == 0) ? len * b_width(sz) : 0);
    check(!chan_on, "R8", "channel off after last item", {31'd0, chan_on}, 0);
    check(xfer_count == CW'(len), "R8", "final count", xfer_count, len);
    check(cur_src == es, "R3", "final source address", cur_src, es);
    check(cur_dst == ed, "R3", "final destination address", cur_dst, ed);
    check(done_flag, "R10", "done flag", {31'd0, done_flag}, 1);
    check(half_flag == (len >= 2), "R10", "half flag", {31'd0, half_flag}, (len >= 2));
    clear_flags();
  endtask

  initial begin
    logic [31:0] orig [0:15];
    void'($urandom(32'h5eed_2024));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!chan_on && !rd_valid && !wr_valid, "R1", "idle at reset",
          {29'd0, chan_on, rd_valid, wr_valid}, 0);
    check(!cfg_err && !half_flag && !done_flag && xfer_count == 0, "R1", "status at reset",
          {13'd0, cfg_err, half_flag, done_flag, xfer_count}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    traffic = 1;

    // R6 R7: 32-bit swap in place
    for (int i = 0; i < 8; i++) orig[i] = mem[8 + i];
    run_normal(5'd0, 5'd0, 2'd0, 1'b1, 32'h20, 32'h20, 8);
    for (int i = 0; i < 8; i++)
      check(mem[8 + i] == {orig[i][7:0], orig[i][15:8], orig[i][23:16], orig[i][31:24]},
            "R7", "in-place 32-bit swap", mem[8 + i],
            {orig[i][7:0], orig[i][15:8], orig[i][23:16], orig[i][31:24]});

    // R6 R5: 16-bit swap in place
    for (int i = 0; i < 4; i++) orig[i] = mem[24 + i];
    run_normal(5'd0, 5'd0, 2'd1, 1'b1, 32'h60, 32'h60, 8);
    for (int i = 0; i < 4; i++)
      check(mem[24 + i] == {orig[i][23:16], orig[i][31:24], orig[i][7:0], orig[i][15:8]},
            "R6", "in-place 16-bit swap", mem[24 + i],
            {orig[i][23:16], orig[i][31:24], orig[i][7:0], orig[i][15:8]});

    // R6: 8-bit with swap set is unchanged
    run_normal(5'd0, 5'd0, 2'd2, 1'b1, 32'h13, 32'h241, 7);

    // R3: peripheral source, peripheral destination, length 1 (no half flag)
    run_normal(5'd0, 5'd9, 2'd0, 1'b0, 32'h100, 32'h280, 5);
    run_normal(5'd17, 5'd0, 2'd1, 1'b1, 32'h42, 32'h104, 6);
    run_normal(5'd0, 5'd0, 2'd2, 1'b0, 32'h0, 32'h2F0, 1);

    // R4: reserved size and zero length
    @(negedge clk);
    cfg_word = 32'h0000_0C00; xfer_len = 4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(cfg_err && !chan_on, "R4", "reserved size refused", {30'd0, cfg_err, chan_on}, 2);
    cfg_word = 32'h0; xfer_len = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(cfg_err && !chan_on, "R4", "zero length refused", {30'd0, cfg_err, chan_on}, 2);
    run_normal(5'd0, 5'd0, 2'd0, 1'b0, 32'h0, 32'h200, 2);
    check(!cfg_err, "R4", "error cleared by good start", {31'd0, cfg_err}, 0);

    // R9 R11 R10: circular laps then abort
    ie_half = 1'b0; ie_done = 1'b1;
    launch(5'd0, 5'd0, 2'd0, 1'b1, 1'b1, 32'h40, 32'h40, 4);
    while (wr_seen < 10) @(negedge clk);
    check(chan_on, "R9", "still on after laps", {31'd0, chan_on}, 1);
    check(done_flag && irq_done, "R10", "done fires in circular", {30'd0, done_flag, irq_done}, 3);
    check(half_flag && !irq_half, "R10", "half masked", {30'd0, half_flag, irq_half}, 2);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_idle();
    check(!chan_on, "R11", "idle after abort", {31'd0, chan_on}, 0);
    check(xfer_count == CW'(wr_seen % 4), "R9", "count wraps per lap", xfer_count, wr_seen % 4);
    check(cur_dst == 32'h40 + (wr_seen % 4) * 4, "R9", "address reloaded per lap",
          cur_dst, 32'h40 + (wr_seen % 4) * 4);
    ie_half = 1'b1;
    @(negedge clk);
    check(irq_half, "R10", "half irq when enabled", {31'd0, irq_half}, 1);
    @(negedge clk); flag_clr = 2'b01;
    @(negedge clk); flag_clr = 2'b00;
    check(!half_flag && done_flag, "R10", "clear only half", {30'd0, half_flag, done_flag}, 1);
    clear_flags();

    // R11: abort mid normal transfer, state held
    launch(5'd0, 5'd0, 2'd1, 1'b0, 1'b0, 32'h0, 32'h200, 20);
    while (wr_seen < 3) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    check(!chan_on && xfer_count == CW'(wr_seen), "R11", "count held after abort",
          xfer_count, wr_seen);
    check(cur_src == wr_seen * 2, "R11", "source held after abort", cur_src, wr_seen * 2);
    // R2: start while running is ignored
    launch(5'd0, 5'd0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h200, 6);
    @(negedge clk);
    cfg_word = 32'h0000_0800; src_base = 32'h80; xfer_len = 2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();
    check(xfer_count == 6 && cur_src == 32'd24, "R2", "restart ignored while on",
          {xfer_count, cur_src[15:0]}, {16'd6, 16'd24});
    clear_flags();

    // R2 R3 R5 R6: random configurations
    for (int n = 0; n < 24; n++) begin
      logic [1:0] sz;
      logic [4:0] sid, did;
      int len, w;
      sz  = 2'($urandom % 3);
      w   = b_width(sz);
      sid = ($urandom % 3 == 0) ? 5'(1 + $urandom % 31) : 5'd0;
      did = ($urandom % 3 == 0) ? 5'(1 + $urandom % 31) : 5'd0;
      len = 1 + $urandom % 16;
      run_normal(did, sid, sz, 1'($urandom), 32'(($urandom % 64) * w) & 32'hFF,
                 32'h200 + (32'(($urandom % 48) * w) & 32'hBF), len);
    end

    traffic = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule